// File: doc/BRIEF.md
# Idle Mode Timer and Wakeup Controller

This block holds a processor core in a low-power idle state and brings it back out. A free-running 16-bit down-counter advances once per instruction cycle, paced by a clock-enable tick. Software cannot read, write, start or stop it, and reset leaves its count alone. A 3-bit tap code chooses which power-of-two boundary of the counter counts as an underflow. The choices are 4096, 8192, 16384, 32768 or 65536 instruction cycles.

Each underflow sets a latched pending flag. The flag stays set until software clears it with a clear strobe, and an enable input decides whether it raises an interrupt request. A write strobe requests idle, and the core-run output then goes low. Idle ends on an underflow of the selected tap, on the external wakeup input, or on reset. Because the counter runs freely, an idle period lasts from 1 instruction cycle up to the selected period.

After every wakeup, the stall output stays high for two instruction cycles while the core clock settles. A test-only preload port sets the counter, so that idle lengths can be checked exactly.

Top module: `idle_wake_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released: core_run_o=1, stall_o=0, pend_o=0, irq_o=0, and the tap code is 0. Internal logic leaves reset on the second rising clock edge after rst_ni rises.
- R2: A high idle_req_i while running drives core_run_o low from the next clock edge. A high idle_req_i while idle has no effect.
- R3: The counter decreases by one on each edge where icyc_en_i=1 and holds otherwise. With tap code c in 0..4, an underflow is a tick on which the low 12+c counter bits are all zero, so the period is 2^(12+c) ticks. Codes 5, 6 and 7 behave as code 4, which uses all 16 bits.
- R4: An underflow sets pend_o at that edge, whether idle or running and whatever irq_en_i is.
- R5: irq_o equals pend_o AND irq_en_i, with no added cycle.
- R6: A pend_clr_i strobe clears pend_o at the next edge. If an underflow happens in the same cycle, pend_o stays set.
- R7: An underflow while idle returns core_run_o to 1 at the same edge that sets pend_o. After a preload to v and entry with ticks on every cycle, core_run_o is low for (v mod period)+1 cycles.
- R8: A high mwake_i while idle ends idle at the next edge. While running it has no effect.
- R9: stall_o goes high at the wakeup edge and stays high for exactly 2 instruction ticks. Clocks without a tick do not shorten it.
- R10: A low rst_ni ends idle at once, without waiting for a clock edge, and clears pend_o and stall_o.
- R11: When tst_load_i is high, tst_value_i loads into the counter at the next edge, taking priority over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| icyc_en_i | input | 1 | Instruction-cycle tick (clock enable) |
| idle_req_i | input | 1 | Write strobe requesting idle |
| tap_wr_i | input | 1 | Tap code write strobe |
| tap_sel_i | input | 3 | Tap code, 0..4 = 4k..64k, 5..7 = 64k |
| irq_en_i | input | 1 | Interrupt enable |
| pend_clr_i | input | 1 | Pending flag clear strobe |
| mwake_i | input | 1 | External wakeup |
| tst_load_i | input | 1 | Test preload strobe |
| tst_value_i | input | 16 | Test preload value |
| core_run_o | output | 1 | Core run enable, low while idle |
| stall_o | output | 1 | Clock resynchronization stall |
| pend_o | output | 1 | Latched underflow pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each registered result is due at the first edge after its cause: idle entry, idle exit, pending set or clear, preload, and the count step. stall_o then falls after two further ticks. irq_o follows irq_en_i in the same cycle. The bench drives inputs on the falling edge and samples 2 ns later. It compares every cycle against a reference model that steps on the rising edge, using the rules above. Directed runs count the low cycles of core_run_o and compare them with (v mod period)+1 from a bench function. These runs include the 1-cycle minimum, a full 4096-cycle period, and codes above 4.

// File: rtl/iwk_pkg.sv
package iwk_pkg;
  localparam int unsigned IWK_CNT_W     = 16;
  localparam int unsigned IWK_BASE_LOG2 = 12;
  localparam int unsigned IWK_NUM_TAPS  = 5;
  localparam int unsigned IWK_SEL_W     = 3;
  localparam int unsigned IWK_STALL_CYC = 2;

  typedef enum logic {
    PM_RUN  = 1'b0,
    PM_IDLE = 1'b1
  } pm_state_e;
endpackage

// File: rtl/iwk_rst_sync.sv
module iwk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/iwk_timer.sv
module iwk_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned NUM_TAPS  = 5,
  parameter int unsigned SEL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tap_wr_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             hit_o
);
  localparam logic [SEL_W-1:0] MAX_IDX = SEL_W'(NUM_TAPS - 1);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SEL_W-1:0]    tap_q, tap_d;
  logic [SEL_W-1:0]    eff_sel;
  logic [NUM_TAPS-1:0] tap_zero;
  logic                sel_zero;

  // Counter: no reset, advances only on the instruction tick
  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_d;
  end

  always_comb begin
    tap_d = tap_q;
    if (tap_wr_i) tap_d = tap_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= '0;
    else         tap_q <= tap_d;
  end

  // One zero-detect per tap boundary
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int unsigned HI = BASE_LOG2 + t;
    assign tap_zero[t] = ~|cnt_q[HI-1:0];
  end

  assign eff_sel = (tap_q > MAX_IDX) ? MAX_IDX : tap_q;

  always_comb begin
    sel_zero = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (eff_sel == SEL_W'(i)) sel_zero = tap_zero[i];
    end
  end

  assign hit_o = tick_i & sel_zero;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q))
    else $error("timer moved without tick");

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("timer did not step by one");

  p_preload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)))
    else $error("preload not taken");
endmodule

// File: rtl/iwk_pwr_ctrl.sv
module iwk_pwr_ctrl
  import iwk_pkg::*;
#(
  parameter int unsigned STALL_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_req_i,
  input  logic hit_i,
  input  logic mwake_i,
  output logic core_run_o,
  output logic stall_o
);
  localparam int unsigned SC_W = $clog2(STALL_CYC + 1);

  pm_state_e       state_q, state_d;
  logic [SC_W-1:0] stall_q, stall_d;
  logic            wake;
  logic            in_idle;

  assign in_idle = (state_q == PM_IDLE);
  assign wake    = hit_i | mwake_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_RUN:  if (idle_req_i) state_d = PM_IDLE;
      PM_IDLE: if (wake)       state_d = PM_RUN;
      default: state_d = PM_RUN;
    endcase
  end

  always_comb begin
    stall_d = stall_q;
    if (in_idle && wake)                 stall_d = SC_W'(STALL_CYC);
    else if (tick_i && (stall_q != '0))  stall_d = stall_q - SC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      stall_q <= '0;
    end else begin
      state_q <= state_d;
      stall_q <= stall_d;
    end
  end

  assign core_run_o = ~in_idle;
  assign stall_o    = (stall_q != '0);

  p_enter_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_idle && idle_req_i) |=> !core_run_o)
    else $error("idle request not taken");

  p_stay_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && !hit_i && !mwake_i) |=> in_idle)
    else $error("idle left without cause");

  p_hit_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && hit_i) |=> core_run_o)
    else $error("underflow did not wake");

  p_ext_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && mwake_i) |=> core_run_o)
    else $error("external wakeup ignored");

  p_stall_on_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_idle) |-> stall_o)
    else $error("no stall after wake");

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !tick_i) |=> stall_o)
    else $error("stall ended without tick");
endmodule

// File: rtl/iwk_pend.sv
module iwk_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (hit_i)      pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & irq_en_i;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q)
    else $error("pending dropped without clear");

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !pend_q)
    else $error("clear not taken");
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import iwk_pkg::*;
#(
  parameter int unsigned CNT_W     = IWK_CNT_W,
  parameter int unsigned BASE_LOG2 = IWK_BASE_LOG2,
  parameter int unsigned NUM_TAPS  = IWK_NUM_TAPS,
  parameter int unsigned SEL_W     = IWK_SEL_W,
  parameter int unsigned STALL_CYC = IWK_STALL_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             icyc_en_i,
  input  logic             idle_req_i,
  input  logic             tap_wr_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic             irq_en_i,
  input  logic             pend_clr_i,
  input  logic             mwake_i,
  input  logic             tst_load_i,
  input  logic [CNT_W-1:0] tst_value_i,
  output logic             core_run_o,
  output logic             stall_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic rst_n;
  logic hit;

  iwk_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  iwk_timer #(
    .CNT_W     (CNT_W),
    .BASE_LOG2 (BASE_LOG2),
    .NUM_TAPS  (NUM_TAPS),
    .SEL_W     (SEL_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (icyc_en_i),
    .tap_wr_i   (tap_wr_i),
    .tap_sel_i  (tap_sel_i),
    .load_i     (tst_load_i),
    .load_val_i (tst_value_i),
    .hit_o      (hit)
  );

  iwk_pwr_ctrl #(
    .STALL_CYC (STALL_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (icyc_en_i),
    .idle_req_i (idle_req_i),
    .hit_i      (hit),
    .mwake_i    (mwake_i),
    .core_run_o (core_run_o),
    .stall_o    (stall_o)
  );

  iwk_pend u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hit_i    (hit),
    .clr_i    (pend_clr_i),
    .irq_en_i (irq_en_i),
    .pend_o   (pend_o),
    .irq_o    (irq_o)
  );

  p_hit_sets_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit |=> pend_o)
    else $error("underflow did not set pending");

  p_reset_run_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (core_run_o && !pend_o && !stall_o))
    else $error("reset did not end idle");
endmodule

// File: tb/tb_idle_wake_ctrl.sv
`timescale 1ns/1ps
module tb_idle_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick, idle_req, tap_wr, irq_en, pend_clr, mwake, tst_load;
  logic [2:0]  tap_sel;
  logic [15:0] tst_value;
  logic        core_run, stall, pend, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  idle_wake_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .icyc_en_i(tick), .idle_req_i(idle_req),
    .tap_wr_i(tap_wr), .tap_sel_i(tap_sel), .irq_en_i(irq_en),
    .pend_clr_i(pend_clr), .mwake_i(mwake), .tst_load_i(tst_load),
    .tst_value_i(tst_value), .core_run_o(core_run), .stall_o(stall),
    .pend_o(pend), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap_log2(input int code);
    return 12 + ((code > 4) ? 4 : code);
  endfunction

  function automatic int exp_idle(input int v, input int code);
    return (v % (1 << tap_log2(code))) + 1;
  endfunction

  // Reference model, stepped on rising edges from the requirements
  logic [15:0] m_cnt;
  int  m_tap, m_stall;
  bit  m_idle, m_pend, m_s1, m_s2, m_known = 1'b0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_idle = 0; m_pend = 0; m_stall = 0; m_tap = 0;
    end else begin
      bit hit;
      bit fell;
      hit = tick && ((m_cnt & 16'((1 << tap_log2(m_tap)) - 1)) == 16'd0);
      if (m_s2) begin
        fell = 0;
        if (m_idle) begin
          if (hit || mwake) begin m_idle = 0; fell = 1; end
        end else if (idle_req) m_idle = 1;
        if (fell) m_stall = 2;
        else if (tick && m_stall > 0) m_stall--;
        if (hit) m_pend = 1;
        else if (pend_clr) m_pend = 0;
        if (tap_wr) m_tap = int'(tap_sel);
      end
      if (tst_load) begin m_cnt = tst_value; m_known = 1; end
      else if (tick) m_cnt = m_cnt - 16'd1;
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_ni && m_known && !done) begin
      chk(core_run == !m_idle, "R7 core_run vs model", core_run, !m_idle);
      chk(pend == m_pend, "R4 pend vs model", pend, m_pend);
      chk(irq == (m_pend & irq_en), "R5 irq vs model", irq, m_pend & irq_en);
      chk(stall == (m_stall != 0), "R9 stall vs model", stall, m_stall != 0);
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic run_idle(input int v, input int code, input bit wr, input string tag);
    int n, s, e;
    @(negedge clk);
    tick = 0; pend_clr = 1; tst_load = 1; tst_value = v[15:0];
    tap_wr = wr; tap_sel = code[2:0];
    @(negedge clk);
    pend_clr = 0; tst_load = 0; tap_wr = 0; idle_req = 1;
    @(negedge clk);
    idle_req = 0; tick = 1; n = 0;
    #2;
    while (!core_run && n < 70000) begin
      n++;
      @(negedge clk); #2;
    end
    e = exp_idle(v, wr ? code : 0);
    chk(n == e, tag, n, e);
    chk(pend == 1'b1, "R4 pend set by wake", pend, 1);
    s = 0;
    while (stall && s < 10) begin
      s++;
      @(negedge clk); #2;
    end
    chk(s == 2, "R9 stall length", s, 2);
  endtask

  initial begin
    void'($urandom(32'h1d1e5eed));
    rst_ni = 0; tick = 0; idle_req = 0; tap_wr = 0; tap_sel = 0; irq_en = 0;
    pend_clr = 0; mwake = 0; tst_load = 0; tst_value = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(core_run == 1, "R1 core_run in reset", core_run, 1);
    chk(pend == 0, "R1 pend in reset", pend, 0);
    chk(irq == 0, "R1 irq in reset", irq, 0);
    chk(stall == 0, "R1 stall in reset", stall, 0);
    @(negedge clk); rst_ni = 1;
    repeat (3) @(negedge clk);
    #2;
    chk(core_run == 1 && stall == 0 && pend == 0, "R1 after release", core_run, 1);

    // R1: default tap is 4096; R11 preload gives exact lengths
    run_idle(100, 0, 0, "R1 R11 default tap idle length");
    irq_en = 0; #2 chk(irq == 0, "R5 irq masked", irq, 0);
    @(negedge clk); irq_en = 1; #2 chk(irq == 1, "R5 irq enabled", irq, 1);
    @(negedge clk); irq_en = 0;
    run_idle(0,      0, 1, "R7 minimum one cycle idle");
    run_idle(4095,   0, 1, "R7 full 4096 period");
    run_idle(8191,   1, 1, "R3 tap 8k");
    run_idle(16'h5000, 2, 1, "R3 tap 16k wrap");
    run_idle(32771,  3, 1, "R3 tap 32k");
    run_idle(16'h1234, 4, 1, "R3 tap 64k");
    run_idle(70,     7, 1, "R3 code 7 acts as 64k");
    run_idle(300,    5, 1, "R3 code 5 acts as 64k");

    // R6: clear and underflow in the same cycle
    @(negedge clk); tick = 0; tst_load = 1; tst_value = 16'd2; tap_wr = 1; tap_sel = 0; pend_clr = 1;
    @(negedge clk); tst_load = 0; tap_wr = 0; tick = 1;
    @(negedge clk);
    @(negedge clk); #2 chk(pend == 0, "R6 cleared before underflow", pend, 0);
    @(negedge clk); #2 chk(pend == 1, "R6 underflow beats clear", pend, 1);
    tick = 0;
    @(negedge clk); #2 chk(pend == 0, "R6 clear takes effect", pend, 0);
    pend_clr = 0;

    // R3: no tick, no underflow, no wake
    @(negedge clk); tst_load = 1; tst_value = 0;
    @(negedge clk); tst_load = 0; idle_req = 1;
    @(negedge clk); idle_req = 0;
    repeat (10) @(negedge clk);
    #2 chk(core_run == 0, "R3 idle holds without tick", core_run, 0);
    @(negedge clk); idle_req = 1;
    @(negedge clk); idle_req = 0;
    #2 chk(core_run == 0, "R2 request while idle ignored", core_run, 0);
    tick = 1;
    @(negedge clk); tick = 0;
    #2 chk(core_run == 1, "R7 wake on single tick", core_run, 1);
    repeat (5) @(negedge clk);
    #2 chk(stall == 1, "R9 stall waits for ticks", stall, 1);
    tick = 1;
    repeat (2) @(negedge clk);
    #2 chk(stall == 0, "R9 stall ends after two ticks", stall, 0);

    // R8: external wakeup
    @(negedge clk); tst_load = 1; tst_value = 16'd1000; tap_wr = 1; tap_sel = 4; pend_clr = 1;
    @(negedge clk); tst_load = 0; tap_wr = 0; pend_clr = 0; mwake = 1;
    repeat (3) @(negedge clk);
    #2 chk(core_run == 1 && stall == 0, "R8 wakeup while running ignored", stall, 0);
    mwake = 0; idle_req = 1;
    @(negedge clk); idle_req = 0;
    #2 chk(core_run == 0, "R2 idle entered", core_run, 0);
    @(negedge clk); mwake = 1;
    @(negedge clk); mwake = 0;
    #2 chk(core_run == 1, "R8 external wake", core_run, 1);
    chk(stall == 1, "R9 stall after external wake", stall, 1);
    chk(pend == 0, "R8 external wake leaves pend", pend, 0);

    // R10: asynchronous reset during idle
    repeat (3) @(negedge clk);
    idle_req = 1;
    @(negedge clk); idle_req = 0;
    #2 chk(core_run == 0, "R2 idle before reset", core_run, 0);
    #3 rst_ni = 0;
    #1 chk(core_run == 1 && stall == 0 && pend == 0, "R10 async reset ends idle", core_run, 1);
    @(negedge clk); rst_ni = 1;
    repeat (3) @(negedge clk);

    // Constrained random phase checked against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick     = ($urandom_range(0, 99) < 70);
      idle_req = ($urandom_range(0, 99) < 3);
      mwake    = ($urandom_range(0, 99) < 2);
      pend_clr = ($urandom_range(0, 99) < 5);
      tap_wr   = ($urandom_range(0, 99) < 1);
      tap_sel  = 3'($urandom_range(0, 7));
      tst_load = ($urandom_range(0, 99) < 1);
      tst_value = 16'($urandom_range(0, 300));
      if ($urandom_range(0, 99) < 10) irq_en = ~irq_en;
    end
    @(negedge clk);
    tick = 0; idle_req = 0; pend_clr = 0; tap_wr = 0; tst_load = 0; mwake = 0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule